// File: doc/BRIEF.md
# Cursor overlay generator

This block produces a small hardware cursor plane for a video pipeline. A timing generator supplies the current pixel number, line number, an active-pixel flag, a vertical-blank flag and a one-cycle frame-start pulse. A register write port sets the cursor position, its size, the row pitch and base of the cursor image, an active window and a control word. The cursor image lives in a local byte memory with one 8-bit palette index per pixel. Each index carries 2 bits each of alpha, red, green and blue.

For every coordinate presented, the block reports whether the cursor covers that pixel. It also returns the colour found by passing the pixel's index through a 256-entry, 16-bit ARGB4444 palette. New palette entries are written into a staging copy through a dedicated write port. The visible copy changes only when a reload has been requested and vertical blanking arrives, so no frame ever mixes old and new colours. Position and size are shadowed and take effect at the next frame start.

Top module: `cursor_overlay`

## Requirements
- R1: After reset `cur_valid` is 0 and `reload_pending` is 0. The cursor size is zero after reset, so no pixel is covered until a size is programmed.
- R2: A pixel (x, y) with `tg_active` high is covered when X0 <= x < X0+W and Y0 <= y < Y0+H. A pixel with `tg_active` low is never covered.
- R3: Coverage also requires the pixel to lie inside the active window, with both ends inclusive. The window start and end registers each hold the line number in bits 31:16 and the pixel number in bits 15:0. After reset the window spans 0 to 0xFFFF on both axes. Window writes take effect immediately.
- R4: A width or height outside 1..128 gives no coverage anywhere. A width of exactly 128 covers X0..X0+127.
- R5: The index for a covered pixel is read from byte address base + (y-Y0)*pitch + (x-X0) of the image memory. The pitch is counted in pixels.
- R6: Registers are selected by byte offset: control 0x00, position 0x0C, image base 0x14, pitch 0x18 (bits 11:0), size 0x1C, palette pointer 0x20, window start 0x28, window end 0x2C. Position holds X0 in bits 11:0 and Y0 in bits 27:16. Size holds W in bits 10:0 and H in bits 26:16.
- R7: Writes to position and size have no visible effect until a cycle with `tg_sof` high. The new values apply from the following cycle.
- R8: Index bits are A[7:6], R[5:4], G[3:2], B[1:0]. After reset the palette maps a 2-bit value v to the nibble 5*v for each component. The output colour is ARGB4444, with A in bits 15:12, R in 11:8, G in 7:4 and B in 3:0.
- R9: Writing the palette pointer register loads an 8-bit entry pointer from bits 7:0. Each `clut_wr` stores `clut_wdata` in the staging entry at the pointer and then increments the pointer. Staged entries are not visible before a reload.
- R10: Writing control with bit 1 set raises `reload_pending`. Writing control with bit 1 clear has no effect. On the first cycle with `tg_vblank` high while a reload is pending, the staging palette is copied to the visible palette and `reload_pending` clears.
- R11: `cur_valid` and `cur_argb` reflect the coordinates presented two clock edges earlier. `cur_argb` is 0 when `cur_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tg_x | input | 12 | Current pixel number |
| tg_y | input | 12 | Current line number |
| tg_active | input | 1 | Pixel is in the active area |
| tg_vblank | input | 1 | Vertical blanking interval |
| tg_sof | input | 1 | Frame-start pulse, latches shadowed geometry |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| pix_wr | input | 1 | Cursor image byte write strobe |
| pix_waddr | input | PM_AW | Cursor image byte address |
| pix_wdata | input | 8 | Cursor image palette index |
| clut_wr | input | 1 | Staging palette write strobe |
| clut_wdata | input | 16 | Staging palette ARGB4444 entry |
| cur_valid | output | 1 | Cursor covers the pixel |
| cur_argb | output | 16 | Cursor colour, ARGB4444 |
| reload_pending | output | 1 | Palette reload requested and not yet applied |

## Verification
Any corruption of the shadowed geometry or the window shows up as a wrong `cur_valid` two cycles after the first affected coordinate. The bench probes every edge of the cursor rectangle and of the window, so such a fault is seen at once. A wrong image address or pitch shows up as a wrong colour at a covered pixel, because every byte of the image is different from its neighbours. A palette that swaps too early shows its new colour before the blanking pulse. A reload that never finishes leaves `reload_pending` high one cycle after blanking.

// File: rtl/cur_pkg.sv
package cur_pkg;
  localparam int IDX_W   = 8;
  localparam int ARGB_W  = 16;
  localparam int COORD_W = 12;
  localparam int DIM_W   = 11;
  localparam int WIN_W   = 16;

  // register word indices (byte offset / 4)
  localparam logic [3:0] RG_CTRL   = 4'd0;
  localparam logic [3:0] RG_POS    = 4'd3;
  localparam logic [3:0] RG_BASE   = 4'd5;
  localparam logic [3:0] RG_PITCH  = 4'd6;
  localparam logic [3:0] RG_SIZE   = 4'd7;
  localparam logic [3:0] RG_CPTR   = 4'd8;
  localparam logic [3:0] RG_WSTART = 4'd10;
  localparam logic [3:0] RG_WEND   = 4'd11;

  // 2-bit component v expands to nibble 5*v, which is {v,v}
  function automatic logic [ARGB_W-1:0] default_argb(input logic [IDX_W-1:0] idx);
    return {idx[7:6], idx[7:6], idx[5:4], idx[5:4],
            idx[3:2], idx[3:2], idx[1:0], idx[1:0]};
  endfunction

  // start <= pos < start + len
  function automatic logic in_span(input logic [COORD_W-1:0] pos,
                                   input logic [COORD_W-1:0] start,
                                   input logic [DIM_W-1:0]   len);
    logic [COORD_W:0] p, s, e;
    p = {1'b0, pos};
    s = {1'b0, start};
    e = s + {{(COORD_W+1-DIM_W){1'b0}}, len};
    return (p >= s) && (p < e);
  endfunction

  function automatic logic [31:0] pix_offset(input logic [31:0] base,
                                             input logic [31:0] row,
                                             input logic [31:0] col,
                                             input logic [31:0] pitch);
    return base + row * pitch + col;
  endfunction
endpackage

// File: rtl/cur_regs.sv
module cur_regs
  import cur_pkg::*;
#(
  parameter int PM_AW = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [5:0]         addr,
  input  logic [31:0]        wdata,
  input  logic               tg_sof,
  input  logic               reload_done,
  output logic [COORD_W-1:0] sh_x,
  output logic [COORD_W-1:0] sh_y,
  output logic [DIM_W-1:0]   sh_w,
  output logic [DIM_W-1:0]   sh_h,
  output logic [PM_AW-1:0]   pm_base,
  output logic [COORD_W-1:0] pm_pitch,
  output logic [WIN_W-1:0]   ws_x,
  output logic [WIN_W-1:0]   ws_y,
  output logic [WIN_W-1:0]   we_x,
  output logic [WIN_W-1:0]   we_y,
  output logic               cptr_load,
  output logic [IDX_W-1:0]   cptr_val,
  output logic               reload_pending
);
  logic [3:0]         widx;
  logic [COORD_W-1:0] pend_x, pend_y;
  logic [DIM_W-1:0]   pend_w, pend_h;
  logic               reload_req;

  assign widx       = addr[5:2];
  assign reload_req = wr && (widx == RG_CTRL) && wdata[1];
  assign cptr_load  = wr && (widx == RG_CPTR);
  assign cptr_val   = wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_x <= '0; pend_y <= '0; pend_w <= '0; pend_h <= '0;
      pm_base <= '0; pm_pitch <= '0;
      ws_x <= '0; ws_y <= '0; we_x <= '1; we_y <= '1;
    end else if (wr) begin
      case (widx)
        RG_POS:    begin pend_x <= wdata[11:0]; pend_y <= wdata[27:16]; end
        RG_SIZE:   begin pend_w <= wdata[10:0]; pend_h <= wdata[26:16]; end
        RG_BASE:   pm_base  <= wdata[PM_AW-1:0];
        RG_PITCH:  pm_pitch <= wdata[11:0];
        RG_WSTART: begin ws_x <= wdata[15:0]; ws_y <= wdata[31:16]; end
        RG_WEND:   begin we_x <= wdata[15:0]; we_y <= wdata[31:16]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_x <= '0; sh_y <= '0; sh_w <= '0; sh_h <= '0;
    end else if (tg_sof) begin
      sh_x <= pend_x; sh_y <= pend_y; sh_w <= pend_w; sh_h <= pend_h;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           reload_pending <= 1'b0;
    else if (reload_req)  reload_pending <= 1'b1;
    else if (reload_done) reload_pending <= 1'b0;
  end

  a_r7_shadow_at_sof: assert property (@(posedge clk) disable iff (!rst_n)
    ({sh_x, sh_y, sh_w, sh_h} != $past({sh_x, sh_y, sh_w, sh_h})) |-> $past(tg_sof));
  a_r10_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> reload_pending);
endmodule

// File: rtl/cur_clut.sv
module cur_clut
  import cur_pkg::*;
#(
  parameter int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic [IDX_W-1:0]  ptr_val,
  input  logic              wr,
  input  logic [ARGB_W-1:0] wdata,
  input  logic              apply,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ARGB_W-1:0] rd_argb
);
  logic [ARGB_W-1:0] stg [ENTRIES];
  logic [ARGB_W-1:0] act [ENTRIES];
  logic [IDX_W-1:0]  ptr;

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr <= '0;
    else if (ptr_load) ptr <= ptr_val;
    else if (wr)       ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) stg[i] <= default_argb(IDX_W'(i));
    end else if (wr) begin
      stg[ptr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) act[i] <= default_argb(IDX_W'(i));
    end else if (apply) begin
      for (int i = 0; i < ENTRIES; i++) act[i] <= stg[i];
    end
  end

  assign rd_argb = act[rd_idx];

  a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ptr_load) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/cur_pixmem.sv
module cur_pixmem
  import cur_pkg::*;
#(
  parameter int PM_AW = 12
) (
  input  logic             clk,
  input  logic             wr,
  input  logic [PM_AW-1:0] waddr,
  input  logic [IDX_W-1:0] wdata,
  input  logic [PM_AW-1:0] raddr,
  output logic [IDX_W-1:0] rdata
);
  localparam int DEPTH = 1 << PM_AW;
  logic [IDX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cur_pkg::*;
#(
  parameter int PM_AW   = 12,
  parameter int MAX_DIM = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       tg_x,
  input  logic [11:0]       tg_y,
  input  logic              tg_active,
  input  logic              tg_vblank,
  input  logic              tg_sof,
  input  logic              reg_wr,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              pix_wr,
  input  logic [PM_AW-1:0]  pix_waddr,
  input  logic [7:0]        pix_wdata,
  input  logic              clut_wr,
  input  logic [15:0]       clut_wdata,
  output logic              cur_valid,
  output logic [15:0]       cur_argb,
  output logic              reload_pending
);
  logic [COORD_W-1:0] sh_x, sh_y, pm_pitch;
  logic [DIM_W-1:0]   sh_w, sh_h;
  logic [PM_AW-1:0]   pm_base;
  logic [WIN_W-1:0]   ws_x, ws_y, we_x, we_y;
  logic               cptr_load;
  logic [IDX_W-1:0]   cptr_val;

  // named internal events
  logic               reload_apply;
  logic               size_ok;
  logic               in_rect;
  logic               in_window;
  logic               cursor_hit;
  logic [31:0]        byte_addr;

  logic               s1_hit, s2_hit;
  logic [PM_AW-1:0]   s1_addr;
  logic [IDX_W-1:0]   s2_idx;
  logic [ARGB_W-1:0]  lut_argb;

  assign reload_apply = reload_pending && tg_vblank;

  cur_regs #(.PM_AW(PM_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .tg_sof(tg_sof), .reload_done(reload_apply),
    .sh_x(sh_x), .sh_y(sh_y), .sh_w(sh_w), .sh_h(sh_h),
    .pm_base(pm_base), .pm_pitch(pm_pitch),
    .ws_x(ws_x), .ws_y(ws_y), .we_x(we_x), .we_y(we_y),
    .cptr_load(cptr_load), .cptr_val(cptr_val), .reload_pending(reload_pending)
  );

  assign size_ok   = (sh_w != '0) && (sh_h != '0) &&
                     (32'(sh_w) <= MAX_DIM) && (32'(sh_h) <= MAX_DIM);
  assign in_rect   = in_span(tg_x, sh_x, sh_w) && in_span(tg_y, sh_y, sh_h);
  assign in_window = (WIN_W'(tg_x) >= ws_x) && (WIN_W'(tg_x) <= we_x) &&
                     (WIN_W'(tg_y) >= ws_y) && (WIN_W'(tg_y) <= we_y);
  assign cursor_hit = tg_active && size_ok && in_rect && in_window;
  assign byte_addr  = pix_offset(32'(pm_base), 32'(tg_y - sh_y),
                                 32'(tg_x - sh_x), 32'(pm_pitch));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_hit  <= 1'b0;
      s1_addr <= '0;
      s2_hit  <= 1'b0;
    end else begin
      s1_hit  <= cursor_hit;
      s1_addr <= byte_addr[PM_AW-1:0];
      s2_hit  <= s1_hit;
    end
  end

  cur_pixmem #(.PM_AW(PM_AW)) u_pixmem (
    .clk(clk), .wr(pix_wr), .waddr(pix_waddr), .wdata(pix_wdata),
    .raddr(s1_addr), .rdata(s2_idx)
  );

  cur_clut u_clut (
    .clk(clk), .rst_n(rst_n), .ptr_load(cptr_load), .ptr_val(cptr_val),
    .wr(clut_wr), .wdata(clut_wdata), .apply(reload_apply),
    .rd_idx(s2_idx), .rd_argb(lut_argb)
  );

  assign cur_valid = s2_hit;
  assign cur_argb  = s2_hit ? lut_argb : '0;

  a_r10_reload_in_vblank: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reload_pending) |-> $past(tg_vblank));
  a_r11_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    cur_valid |-> $past(tg_active, 2));
  a_r11_blank_colour: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_valid |-> (cur_argb == 16'h0000));
endmodule

// File: tb/cursor_overlay_bench.sv
`timescale 1ns/1ps
module cursor_overlay_bench;
  localparam int PM_AW = 12;
  localparam int BASE  = 100;
  localparam int PITCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] tg_x = '0, tg_y = '0;
  logic tg_active = 1'b0, tg_vblank = 1'b0, tg_sof = 1'b0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic pix_wr = 1'b0;
  logic [PM_AW-1:0] pix_waddr = '0;
  logic [7:0] pix_wdata = '0;
  logic clut_wr = 1'b0;
  logic [15:0] clut_wdata = '0;
  logic cur_valid;
  logic [15:0] cur_argb;
  logic reload_pending;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cursor_overlay #(.PM_AW(PM_AW)) u_cursor_overlay (
    .clk(clk), .rst_n(rst_n), .tg_x(tg_x), .tg_y(tg_y), .tg_active(tg_active),
    .tg_vblank(tg_vblank), .tg_sof(tg_sof), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pix_wr(pix_wr), .pix_waddr(pix_waddr),
    .pix_wdata(pix_wdata), .clut_wr(clut_wr), .clut_wdata(clut_wdata),
    .cur_valid(cur_valid), .cur_argb(cur_argb), .reload_pending(reload_pending)
  );

  // {x, y, active, expected valid, pad}
  localparam logic [31:0] VEC [12] = '{
    {12'd10, 12'd5, 1'b1, 1'b1, 6'd0},
    {12'd13, 12'd5, 1'b1, 1'b1, 6'd0},
    {12'd14, 12'd5, 1'b1, 1'b0, 6'd0},
    {12'd9,  12'd5, 1'b1, 1'b0, 6'd0},
    {12'd10, 12'd4, 1'b1, 1'b0, 6'd0},
    {12'd10, 12'd7, 1'b1, 1'b1, 6'd0},
    {12'd13, 12'd7, 1'b1, 1'b1, 6'd0},
    {12'd10, 12'd8, 1'b1, 1'b0, 6'd0},
    {12'd11, 12'd6, 1'b0, 1'b0, 6'd0},
    {12'd12, 12'd6, 1'b1, 1'b1, 6'd0},
    {12'd11, 12'd6, 1'b1, 1'b1, 6'd0},
    {12'd0,  12'd0, 1'b1, 1'b0, 6'd0}
  };

  function automatic int pat(input int row, input int col);
    return ((row * PITCH + col) * 29 + 7) % 256;
  endfunction

  function automatic logic [15:0] def_colour(input int idx);
    int a, r, g, b;
    a = (idx / 64) % 4; r = (idx / 16) % 4; g = (idx / 4) % 4; b = idx % 4;
    return 16'((a * 5) * 4096 + (r * 5) * 256 + (g * 5) * 16 + (b * 5));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse_sof();
    @(negedge clk); tg_sof = 1'b1;
    @(negedge clk); tg_sof = 1'b0;
  endtask

  task automatic probe(input int x, input int y, input bit act,
                       output bit v, output logic [15:0] c);
    @(negedge clk); tg_x = 12'(x); tg_y = 12'(y); tg_active = act;
    repeat (2) @(posedge clk);
    @(negedge clk);
    v = cur_valid; c = cur_argb;
  endtask

  task automatic expect_valid(input int x, input int y, input bit ev, input string req);
    bit v; logic [15:0] c;
    probe(x, y, 1'b1, v, c);
    check(v == ev, req, int'(v), int'(ev));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit v; logic [15:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cur_valid == 1'b0, "R1 valid", int'(cur_valid), 0);
    check(reload_pending == 1'b0, "R1 pending", int'(reload_pending), 0);
    expect_valid(0, 0, 1'b0, "R1 zero size");

    // fill image, full pitch so pitch errors are visible (R5)
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < PITCH; k++) begin
        @(negedge clk); pix_wr = 1'b1;
        pix_waddr = PM_AW'(BASE + r * PITCH + k); pix_wdata = 8'(pat(r, k));
      end
    @(negedge clk); pix_wr = 1'b0;

    // R6 register layout
    wr_reg(6'h0C, {4'd0, 12'd5, 4'd0, 12'd10});
    wr_reg(6'h1C, {5'd0, 11'd3, 5'd0, 11'd4});
    wr_reg(6'h14, 32'(BASE));
    wr_reg(6'h18, 32'(PITCH));
    pulse_sof();

    // R2 R5 R8 R11 vector walk
    for (int i = 0; i < 12; i++) begin
      int x, y; bit act, ev;
      x = int'(VEC[i][31:20]); y = int'(VEC[i][19:8]);
      act = VEC[i][7]; ev = VEC[i][6];
      probe(x, y, act, v, c);
      check(v == ev, "R2 coverage", int'(v), int'(ev));
      if (ev) check(c == def_colour(pat(y - 5, x - 10)), "R5/R8 colour", int'(c),
                    int'(def_colour(pat(y - 5, x - 10))));
      else    check(c == 16'h0, "R11 blank colour", int'(c), 0);
    end

    // R3 window clipping, inclusive ends
    wr_reg(6'h28, {16'd0, 16'd12});
    expect_valid(11, 5, 1'b0, "R3 start clip");
    expect_valid(12, 5, 1'b1, "R3 start edge");
    wr_reg(6'h2C, {16'd6, 16'd639});
    expect_valid(12, 7, 1'b0, "R3 end clip");
    expect_valid(12, 6, 1'b1, "R3 end edge");
    wr_reg(6'h28, 32'h0);
    wr_reg(6'h2C, 32'hFFFF_FFFF);

    // R4 size limits
    wr_reg(6'h1C, {5'd0, 11'd3, 5'd0, 11'd0});
    pulse_sof();
    expect_valid(10, 5, 1'b0, "R4 width 0");
    wr_reg(6'h1C, {5'd0, 11'd3, 5'd0, 11'd129});
    pulse_sof();
    expect_valid(10, 5, 1'b0, "R4 width 129");
    wr_reg(6'h1C, {5'd0, 11'd1, 5'd0, 11'd128});
    pulse_sof();
    expect_valid(137, 5, 1'b1, "R4 width 128 last");
    expect_valid(138, 5, 1'b0, "R4 width 128 past");
    wr_reg(6'h1C, {5'd0, 11'd3, 5'd0, 11'd4});
    pulse_sof();

    // R7 shadowing
    wr_reg(6'h0C, {4'd0, 12'd5, 4'd0, 12'd20});
    expect_valid(10, 5, 1'b1, "R7 before sof");
    pulse_sof();
    expect_valid(10, 5, 1'b0, "R7 after sof old");
    probe(20, 5, 1'b1, v, c);
    check(v && c == def_colour(pat(0, 0)), "R7 after sof new", int'(c),
          int'(def_colour(pat(0, 0))));
    wr_reg(6'h0C, {4'd0, 12'd5, 4'd0, 12'd10});
    pulse_sof();

    // R9 R10 palette reload; pixel (10,5) has index pat(0,0)=7
    wr_reg(6'h20, 32'd6);
    @(negedge clk); clut_wr = 1'b1; clut_wdata = 16'h1111;
    @(negedge clk); clut_wdata = 16'hABCD;
    @(negedge clk); clut_wr = 1'b0;
    probe(10, 5, 1'b1, v, c);
    check(c == def_colour(7), "R9 staged hidden", int'(c), int'(def_colour(7)));
    wr_reg(6'h00, 32'h0);
    check(reload_pending == 1'b0, "R10 bit1 clear no effect", int'(reload_pending), 0);
    wr_reg(6'h00, 32'h2);
    check(reload_pending == 1'b1, "R10 pending set", int'(reload_pending), 1);
    probe(10, 5, 1'b1, v, c);
    check(c == def_colour(7), "R10 no swap before vblank", int'(c), int'(def_colour(7)));
    @(negedge clk); tg_vblank = 1'b1;
    @(negedge clk); tg_vblank = 1'b0;
    check(reload_pending == 1'b0, "R10 pending cleared", int'(reload_pending), 0);
    probe(10, 5, 1'b1, v, c);
    check(c == 16'hABCD, "R9/R10 new entry", int'(c), 16'hABCD);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule